// File: doc/BRIEF.md
# Address-Line Uniqueness Tester

The block is a built-in self-test engine that checks whether each address line of a word-organised memory region selects its own word. On a start pulse it places two anchor words in the region: a fixed marker at the highest word address and the marker's complement at the lowest word address. It then walks a single address bit across every word-address position inside the region. For each bit it writes a distinct value at each anchor's address with that bit flipped.

When every write is done, a second pass reads each anchor and its one-bit neighbour and compares the two words. If an anchor and its neighbour hold equal words, the flipped address line did not reach a separate location, and the bit is marked as ineffective. The result is a mask of failing address bits. A nonzero mask means the region failed. Because both the all-zeros and the all-ones corner are used, a line stuck low and a line stuck high are both caught.

The region is given as an aligned base address and the base-2 logarithm of its size in bytes. The memory port is a plain single-cycle request port. Read data returns one cycle after a read request.

Top module: `addr_alias_tester`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o, fail_o, mem_req_o and every bit of mask_o are 0.
- R2: A start_i high at a clock edge while the engine is idle captures base_i and size_lg_i, clears mask_o and raises busy_o. A start_i that arrives while busy_o is high does not change the memory accesses or the result of the run in progress.
- R3: Address bits of base_i below size_lg_i are ignored. The region base is base_i with those bits cleared, and the top anchor is that base with bits 2 to size_lg_i-1 set.
- R4: The first write puts 32'h5A5AA5A5 at the top anchor. The second write puts 32'hA5A55A5A at the base.
- R5: The write pass then goes through k = 2 to size_lg_i-1 in rising order, with p = 1<<k. For each k it writes ~p (32 bits) to base^p and then writes p, zero-extended, to top^p.
- R6: The read pass starts only after the last write. For each k in rising order it reads base, base^p, top and top^p in that order, and it issues no writes.
- R7: Bit k of mask_o is set when the word read at base equals the word read at base^p, or when the word read at top equals the word read at top^p. Read data is taken on mem_rdata_i in the cycle after the read request.
- R8: Bits of mask_o below 2 and at or above size_lg_i are always 0. fail_o is 1 exactly when mask_o is nonzero.
- R9: done_o is high for one cycle, 2+7n cycles after the start edge, where n = size_lg_i-2. busy_o falls on the next cycle. mask_o then holds until the next accepted start.
- R10: Every memory address is word aligned and lies within the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| base_i | input | AW | Region base byte address |
| size_lg_i | input | $clog2(AW+1) | Log2 of region size in bytes, 3 to AW |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Result mask is nonzero |
| mask_o | output | AW | Ineffective address bits |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, one cycle after the request |

## Verification
A nonzero mask only appears when the memory decodes two addresses onto the same word, and a healthy port model never does that. The bench memory therefore passes every address through a fault stage before indexing its store. The stage can hold an address bit at 0, hold it at 1, or copy one bit onto another. This recreates aliasing of each kind, inside the region and above it. Start pulses in the middle of a run, and unaligned base inputs, are mixed in so that the ignore rules show up in the access stream.

// File: rtl/aat_pkg.sv
package aat_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_W_TOP,
    ST_W_BOT,
    ST_W_LO,
    ST_W_HI,
    ST_C_BA,
    ST_C_BP,
    ST_C_TA,
    ST_C_TP,
    ST_C_END,
    ST_DONE
  } aat_state_e;
endpackage

// File: rtl/aat_pat_ctr.sv
module aat_pat_ctr #(
  parameter int unsigned AW  = 16,
  parameter int unsigned LGW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           adv_i,
  input  logic [LGW-1:0] lg_i,
  output logic [AW-1:0]  pat_o,
  output logic           last_o
);
  logic [LGW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= LGW'(2);
    else if (clr_i)  idx_q <= LGW'(2);
    else if (adv_i)  idx_q <= idx_q + LGW'(1);
  end

  assign pat_o  = AW'(1) << idx_q;
  assign last_o = (idx_q == lg_i - LGW'(1));
endmodule

// File: rtl/aat_seq.sv
module aat_seq
  import aat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       last_i,
  output aat_state_e state_o,
  output logic       clr_o,
  output logic       adv_o
);
  aat_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_W_TOP;
      ST_W_TOP: st_d = ST_W_BOT;
      ST_W_BOT: st_d = ST_W_LO;
      ST_W_LO:  st_d = ST_W_HI;
      ST_W_HI:  st_d = last_i ? ST_C_BA : ST_W_LO;
      ST_C_BA:  st_d = ST_C_BP;
      ST_C_BP:  st_d = ST_C_TA;
      ST_C_TA:  st_d = ST_C_TP;
      ST_C_TP:  st_d = ST_C_END;
      ST_C_END: st_d = last_i ? ST_DONE : ST_C_BA;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  // counter restarts at bit 2 on launch and again between passes
  assign clr_o = (st_q == ST_IDLE && start_i) || (st_q == ST_W_HI && last_i);
  assign adv_o = (st_q == ST_W_HI || st_q == ST_C_END) && !last_i;
endmodule

// File: rtl/aat_mask.sv
module aat_mask
  import aat_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  aat_state_e    state_i,
  input  logic [AW-1:0] pat_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] mask_o
);
  logic [DW-1:0] anc_q;
  logic [AW-1:0] mask_q;

  // anchor data lands while its neighbour read is issued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) anc_q <= '0;
    else if (state_i == ST_C_BP || state_i == ST_C_TP) anc_q <= rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else if ((state_i == ST_C_TA || state_i == ST_C_END) && rdata_i == anc_q)
      mask_q <= mask_q | pat_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/addr_alias_tester.sv
module addr_alias_tester
  import aat_pkg::*;
#(
  parameter int unsigned   AW     = 16,
  parameter int unsigned   DW     = 32,
  parameter logic [DW-1:0] MARKER = DW'(32'h5A5AA5A5),
  localparam int unsigned  LGW    = $clog2(AW + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  base_i,
  input  logic [LGW-1:0] size_lg_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           fail_o,
  output logic [AW-1:0]  mask_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i
);
  aat_state_e     state;
  logic           clr, adv, last, accept;
  logic [AW-1:0]  pat, base_q, top_addr, in_rmask, rmask;
  logic [LGW-1:0] lg_q;

  assign accept   = (state == ST_IDLE) && start_i;
  assign in_rmask = (AW'(1) << size_lg_i) - AW'(1);
  assign rmask    = (AW'(1) << lg_q) - AW'(1);
  assign top_addr = base_q | (rmask & ~AW'(3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      lg_q   <= LGW'(3);
    end else if (accept) begin
      base_q <= base_i & ~in_rmask;
      lg_q   <= size_lg_i;
    end
  end

  aat_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .last_i (last),
    .state_o(state),
    .clr_o  (clr),
    .adv_o  (adv)
  );

  aat_pat_ctr #(.AW(AW), .LGW(LGW)) u_pat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .adv_i (adv),
    .lg_i  (lg_q),
    .pat_o (pat),
    .last_o(last)
  );

  aat_mask #(.AW(AW), .DW(DW)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .state_i(state),
    .pat_i  (pat),
    .rdata_i(mem_rdata_i),
    .mask_o (mask_o)
  );

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    unique case (state)
      ST_W_TOP: begin mem_we_o = 1'b1; mem_addr_o = top_addr;       mem_wdata_o = MARKER;   end
      ST_W_BOT: begin mem_we_o = 1'b1; mem_addr_o = base_q;         mem_wdata_o = ~MARKER;  end
      ST_W_LO:  begin mem_we_o = 1'b1; mem_addr_o = base_q ^ pat;   mem_wdata_o = ~DW'(pat); end
      ST_W_HI:  begin mem_we_o = 1'b1; mem_addr_o = top_addr ^ pat; mem_wdata_o = DW'(pat);  end
      ST_C_BA:  mem_addr_o = base_q;
      ST_C_BP:  mem_addr_o = base_q ^ pat;
      ST_C_TA:  mem_addr_o = top_addr;
      ST_C_TP:  mem_addr_o = top_addr ^ pat;
      default:  mem_req_o = 1'b0;
    endcase
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);
  assign fail_o = |mask_o;
endmodule

// File: rtl/aat_checker.sv
module aat_checker #(
  parameter int unsigned AW  = 16,
  parameter int unsigned LGW = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           fail_o,
  input logic [AW-1:0]  mask_o,
  input logic           mem_req_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic [AW-1:0]  base_q,
  input logic [LGW-1:0] lg_q
);
  logic [AW-1:0] rmask;
  assign rmask = (AW'(1) << lg_q) - AW'(1);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !busy_o); // R9
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_o |-> !mem_req_o); // R1
  AST_ADDR_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R10
  AST_ADDR_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_addr_o ^ base_q) & ~rmask) == '0); // R10
  AST_MASK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & ~(rmask & ~AW'(3))) == '0); // R8
  AST_FAIL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) fail_o == (mask_o != '0)); // R8
  AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(mask_o)); // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(lg_q) && $stable(base_q)); // R2
endmodule

bind addr_alias_tester aat_checker #(.AW(AW), .LGW(LGW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .mask_o    (mask_o),
  .mem_req_o (mem_req_o),
  .mem_addr_o(mem_addr_o),
  .base_q    (base_q),
  .lg_q      (lg_q)
);

// File: tb/addr_alias_tester_tb.sv
`timescale 1ns/1ps
module addr_alias_tester_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LGW = $clog2(AW + 1);
  localparam logic [31:0] MK = 32'h5A5AA5A5;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [31:0] data;
  } txn_t;

  logic clk_i = 0, rst_ni = 0, start_i = 0;
  logic [AW-1:0] base_i = '0;
  logic [LGW-1:0] size_lg_i = LGW'(3);
  logic busy_o, done_o, fail_o, mem_req_o, mem_we_o;
  logic [AW-1:0] mask_o, mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i = '0;

  int total = 0, bad = 0;
  int fmode = 0, fbit = 0, fsrc = 0;
  bit mon_en = 0;
  txn_t exp_q[$];
  logic [31:0] mem [int];
  logic [31:0] ref_m [int];

  always #10 clk_i = ~clk_i;

  addr_alias_tester u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .size_lg_i(size_lg_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .mask_o(mask_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  // faulty address decoder: 1 stuck low, 2 stuck high, 3 bit copies another
  function automatic int phys(logic [15:0] a);
    logic [15:0] x = a;
    case (fmode)
      1: x[fbit] = 1'b0;
      2: x[fbit] = 1'b1;
      3: x[fbit] = x[fsrc];
      default: ;
    endcase
    return int'(x >> 2);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  always @(posedge clk_i) begin
    if (mem_req_o && mem_we_o) mem[phys(mem_addr_o)] = mem_wdata_o;
    else if (mem_req_o) mem_rdata_i <= mem.exists(phys(mem_addr_o)) ? mem[phys(mem_addr_o)] : 32'h0;
  end

  // per-cycle comparison of the access stream with the expected one
  always @(negedge clk_i) begin
    txn_t t;
    if (mon_en && mem_req_o) begin
      if (exp_q.size() == 0) chk(0, "R6", "extra access", {15'd0, mem_we_o, mem_addr_o}, 0);
      else begin
        t = exp_q.pop_front();
        chk(mem_we_o == t.we, "R6", "access kind", 32'(mem_we_o), 32'(t.we));
        chk(mem_addr_o == t.addr, "R5", "access addr", 32'(mem_addr_o), 32'(t.addr));
        if (t.we) chk(mem_wdata_o == t.data, "R4", "write data", mem_wdata_o, t.data);
      end
    end
  end

  function automatic logic [31:0] rd_ref(logic [15:0] a);
    return ref_m.exists(phys(a)) ? ref_m[phys(a)] : 32'h0;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    txn_t t;
    t.we = 1; t.addr = a; t.data = d;
    exp_q.push_back(t);
    ref_m[phys(a)] = d;
  endtask

  task automatic rq(input logic [15:0] a);
    txn_t t;
    t.we = 0; t.addr = a; t.data = 0;
    exp_q.push_back(t);
  endtask

  task automatic run(input logic [15:0] b, input int lg, input bit poke);
    logic [15:0] rm, base, top, p;
    logic [15:0] emask = 0;
    int n = lg - 2, cnt;
    rm = 16'((32'd1 << lg) - 1);
    base = b & ~rm;              // R3 low base bits dropped
    top = base | (rm & ~16'd3);
    exp_q.delete(); ref_m.delete(); mem.delete();
    wr(top, MK); wr(base, ~MK);
    for (int k = 2; k < lg; k++) begin
      p = 16'(1 << k);
      wr(base ^ p, ~{16'd0, p});
      wr(top ^ p, {16'd0, p});
    end
    for (int k = 2; k < lg; k++) begin
      p = 16'(1 << k);
      rq(base); rq(base ^ p); rq(top); rq(top ^ p);
      if (rd_ref(base) == rd_ref(base ^ p)) emask |= p;   // R7
      if (rd_ref(top) == rd_ref(top ^ p)) emask |= p;
    end
    @(negedge clk_i);
    base_i = b; size_lg_i = LGW'(lg); start_i = 1; mon_en = 1;
    @(negedge clk_i);
    start_i = 0; cnt = 1;
    chk(busy_o && !done_o, "R2", "busy after start", 32'(busy_o), 1);
    while (!done_o && cnt < 3000) begin
      if (poke && cnt == 6) begin start_i = 1; base_i = ~b; size_lg_i = LGW'(AW); end
      else start_i = 0;
      @(negedge clk_i); cnt++;
    end
    start_i = 0;
    chk(done_o, "R9", "watchdog done", 32'(done_o), 1);
    chk(cnt == 3 + 7 * n, "R9", "done latency", 32'(cnt), 32'(3 + 7 * n));
    chk(exp_q.size() == 0, "R6", "missing accesses", 32'(exp_q.size()), 0);
    chk(mask_o == emask, "R7", "mask", 32'(mask_o), 32'(emask));
    chk((mask_o & ~(rm & ~16'd3)) == 0, "R8", "mask range", 32'(mask_o), 32'(emask));
    chk(fail_o == (emask != 0), "R8", "fail flag", 32'(fail_o), 32'(emask != 0));
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R9", "done pulse width/busy", {30'd0, done_o, busy_o}, 0);
    repeat (3) @(negedge clk_i);
    chk(mask_o == emask, "R9", "mask held", 32'(mask_o), 32'(emask));
    mon_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !fail_o && !mem_req_o && mask_o == 0, "R1", "reset state",
        {27'd0, busy_o, done_o, fail_o, mem_req_o, |mask_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !mem_req_o && mask_o == 0, "R1", "after release", {30'd0, busy_o, mem_req_o}, 0);
    fmode = 0; run(16'h0000, 16, 0);          // R4 R5 R6 full space clean
    fmode = 0; run(16'h3123, 12, 0);          // R3 unaligned base
    fmode = 1; fbit = 5; run(16'h4000, 10, 0); // R7 stuck low
    fmode = 2; fbit = 9; run(16'h0000, 12, 0); // R7 stuck high
    fmode = 3; fbit = 7; fsrc = 3; run(16'h8000, 12, 0); // R7 shorted pair
    fmode = 0; run(16'h0020, 3, 0);           // R9 smallest region
    fmode = 1; fbit = 4; run(16'hA000, 9, 1); // R2 start while busy ignored
    fmode = 2; fbit = 14; run(16'h1000, 12, 0); // R8 fault above region
    chk(mask_o == 0, "R8", "no mask outside region", 32'(mask_o), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL R9 watchdog expired act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule